// File: doc/BRIEF.md
# Guarded Dual-Lane Arithmetic Right Shifter

This execution unit treats a 32-bit source word as two packed signed 16-bit lanes. It shifts both lanes right arithmetically by one shared count taken from a second 32-bit operand. Bits never cross from one lane into the other. Each lane refills its vacated high positions with its own sign bit. If any bit above the four count bits of the shift operand is set, the shift counts as 16 or more, and each lane becomes a solid copy of its sign.

The result is registered one clock after issue into a destination holding register. The write is predicated. When a guard is supplied, the holding register and the write strobe update only if the guard's least significant bit is 1. When no guard is supplied, the issue always writes.

Top module: `dual_lane_sar`

## Requirements
- R1: The upper lane (bits 31:16) and the lower lane (bits 15:0) are shifted independently. No bit of one lane reaches the other lane's result.
- R2: The shift count is bits 3:0 of the shift operand, and the same count applies to both lanes.
- R3: In each lane, the vacated high positions take that lane's sign bit: bit 31 for the upper lane and bit 15 for the lower lane. The result equals the signed lane value divided by 2^count, rounded toward minus infinity.
- R4: When any of bits 31:4 of the shift operand is 1, each lane's result is 16 copies of its sign bit, whatever bits 3:0 hold.
- R5: With guard_en_i high and guard_i[0] low, an issue leaves dest_o unchanged and raises no strobe. With guard_en_i high and guard_i[0] high, the issue writes. Bits 31:1 of the guard have no effect.
- R6: With guard_en_i low, every issue writes, whatever guard_i holds.
- R7: A synchronous active-high reset sets dest_o to zero and wr_vld_o to 0.
- R8: The result of a writing issue appears on dest_o at the first rising edge after issue, together with wr_vld_o high for exactly that one cycle. dest_o then holds that value until the next write.
- R9: A count of zero with bits 31:4 clear passes the source word through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| issue_i | input | 1 | Issue strobe for one operation |
| src_i | input | 32 | Packed pair of signed 16-bit lanes |
| amt_i | input | 32 | Shift operand: count in bits 3:0, out-of-range flag from bits 31:4 |
| guard_i | input | 32 | Guard word; only bit 0 matters |
| guard_en_i | input | 1 | High when the guard applies |
| dest_o | output | 32 | Destination holding register |
| wr_vld_o | output | 1 | High for one cycle after each write |

## Verification
The assertions assume that every input carries a known value at each rising edge. They also assume that reset is sampled synchronously, so the cycle after a reset edge has a defined prior state to compare against. The stimulus changes inputs only on falling edges and never leaves an operand undriven. It holds issue low between operations wherever a check needs the holding register's value to persist.

// File: rtl/dual_lane_sar.sv
module dual_lane_sar #(
  parameter int LANE_W = 16,
  parameter int LANES  = 2,
  localparam int WORD_W = LANE_W * LANES,
  localparam int CNT_W  = $clog2(LANE_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue_i,
  input  logic [WORD_W-1:0] src_i,
  input  logic [WORD_W-1:0] amt_i,
  input  logic [WORD_W-1:0] guard_i,
  input  logic              guard_en_i,
  output logic [WORD_W-1:0] dest_o,
  output logic              wr_vld_o
);

  logic [WORD_W-1:0] shifted;
  logic [CNT_W-1:0]  cnt;
  logic              over;
  logic              allow;

  assign cnt   = amt_i[CNT_W-1:0];
  assign over  = |amt_i[WORD_W-1:CNT_W];
  assign allow = issue_i & (~guard_en_i | guard_i[0]);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic signed [LANE_W-1:0] lane;
    logic signed [LANE_W-1:0] sh_v;
    assign lane = src_i[g*LANE_W +: LANE_W];
    assign sh_v = lane >>> cnt;
    assign shifted[g*LANE_W +: LANE_W] = over ? {LANE_W{lane[LANE_W-1]}} : sh_v;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dest_o   <= '0;
      wr_vld_o <= 1'b0;
    end else begin
      wr_vld_o <= allow;
      if (allow) dest_o <= shifted;
    end
  end

  p_reset_clear_r7: assert property (@(posedge clk)
    rst |=> (dest_o == '0) && !wr_vld_o);

  p_hold_when_blocked_r5: assert property (@(posedge clk) disable iff (rst)
    !allow |=> $stable(dest_o) && !wr_vld_o);

  p_strobe_after_write_r8: assert property (@(posedge clk) disable iff (rst)
    allow |=> wr_vld_o);

  p_unguarded_writes_r6: assert property (@(posedge clk) disable iff (rst)
    (issue_i && !guard_en_i) |=> wr_vld_o);

  p_zero_count_pass_r9: assert property (@(posedge clk) disable iff (rst)
    (allow && amt_i == '0) |=> dest_o == $past(src_i));

  p_sign_fill_top_r4: assert property (@(posedge clk) disable iff (rst)
    (allow && over) |=> dest_o[WORD_W-1 -: LANE_W] == {LANE_W{$past(src_i[WORD_W-1])}});

  p_sign_fill_low_r4: assert property (@(posedge clk) disable iff (rst)
    (allow && over) |=> dest_o[LANE_W-1:0] == {LANE_W{$past(src_i[LANE_W-1])}});

endmodule

// File: tb/dual_lane_sar_tb_top.sv
`timescale 1ns/1ps
module dual_lane_sar_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        issue_i = 1'b0;
  logic [31:0] src_i = '0, amt_i = '0, guard_i = '0;
  logic        guard_en_i = 1'b0;
  logic [31:0] dest_o;
  logic        wr_vld_o;

  int applied = 0, bad = 0;
  bit done = 0;
  logic [31:0] model = '0;

  always #4 clk = ~clk;

  dual_lane_sar dut_i (.clk(clk), .rst(rst), .issue_i(issue_i), .src_i(src_i),
    .amt_i(amt_i), .guard_i(guard_i), .guard_en_i(guard_en_i),
    .dest_o(dest_o), .wr_vld_o(wr_vld_o));

  function automatic logic [15:0] lane_exp(logic [15:0] v, logic [31:0] a);
    int s, d, r;
    s = v[15] ? int'(v) - 65536 : int'(v);
    if (a[31:4] != 0) r = (s < 0) ? -1 : 0;
    else begin
      d = 1 << a[3:0];
      if (s >= 0) r = s / d;
      else r = -((-s + d - 1) / d);
    end
    return r[15:0];
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    applied++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic op(logic [31:0] s, logic [31:0] a, logic [31:0] g, logic ge, string tag);
    logic wr;
    wr = !ge || g[0];
    @(negedge clk);
    src_i = s; amt_i = a; guard_i = g; guard_en_i = ge; issue_i = 1'b1;
    @(negedge clk);
    issue_i = 1'b0;
    if (wr) model = {lane_exp(s[31:16], a), lane_exp(s[15:0], a)};
    check({tag, " R8 dest"}, dest_o, model);
    check({tag, " R8 strobe"}, {31'b0, wr_vld_o}, {31'b0, wr});
  endtask

  initial begin
    logic [15:0] pats [12];
    logic [31:0] amts [4];
    pats = '{16'h0000, 16'h0001, 16'h7fff, 16'h8000, 16'hffff, 16'h7008,
             16'h4008, 16'h800c, 16'ha5a5, 16'h5a5a, 16'h1234, 16'hfedc};
    amts = '{32'h10, 32'h10000000, 32'h1f, 32'h80000003};
    repeat (3) @(negedge clk);
    check("R7 reset dest", dest_o, 32'h0);
    check("R7 reset strobe", {31'b0, wr_vld_o}, 32'h0);
    rst = 1'b0;

    op(32'h70087008, 32'h1, 0, 0, "R3 ex1");
    check("R3 ex1 value", dest_o, 32'h38043804);
    op(32'h70084008, 32'h4, 1, 1, "R1 ex2");
    check("R1 ex2 value", dest_o, 32'h07000400);
    op(32'h800c800c, 32'h4, 1, 1, "R3 ex3");
    check("R3 ex3 value", dest_o, 32'hf800f800);
    op(32'h700c800c, 32'hf, 1, 1, "R2 ex4");
    check("R2 ex4 value", dest_o, 32'h0000ffff);
    op(32'h800c700c, 32'h10, 1, 1, "R4 ex5");
    check("R4 ex5 value", dest_o, 32'hffff0000);
    op(32'h800c700c, 32'h10000000, 1, 1, "R4 ex6");
    check("R4 ex6 value", dest_o, 32'hffff0000);

    @(negedge clk);
    check("R8 strobe one cycle", {31'b0, wr_vld_o}, 32'h0);
    check("R8 dest held", dest_o, 32'hffff0000);

    op(32'h12345678, 32'h0, 0, 0, "R9 pass");
    check("R9 pass value", dest_o, 32'h12345678);

    op(32'h70087008, 32'h2, 32'h0, 1, "R5 guard low");
    check("R5 unchanged", dest_o, 32'h12345678);
    op(32'h70087008, 32'h2, 32'hfffffffe, 1, "R5 upper guard bits");
    check("R5 upper bits ignored", dest_o, 32'h12345678);
    op(32'h70087008, 32'h2, 32'h00000001, 1, "R5 guard high");
    check("R5 written", dest_o, 32'h1c021c02);
    op(32'h800c700c, 32'h3, 32'hfffffffe, 0, "R6 no guard");
    check("R6 written", {31'b0, wr_vld_o}, 32'h1);

    for (int i = 0; i < 12; i++) begin
      for (int k = 0; k < 20; k++) begin
        logic [31:0] a;
        a = (k < 16) ? 32'(k) : amts[k-16];
        op({pats[i], pats[(i+5)%12]}, a, 0, 0, "R1 R2 R3 R4 sweep");
      end
    end

    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R7 mid reset dest", dest_o, 32'h0);
    check("R7 mid reset strobe", {31'b0, wr_vld_o}, 32'h0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      applied++;
      bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
      $finish;
    end
  end
endmodule